// File: doc/BRIEF.md
# Exception Entry and Return Frame Sequencer

This block handles the hardware part of taking and leaving an exception. When an exception request is accepted, it writes eight words of processor state to the stack through a data-side memory port. In the same cycle it starts reading the handler start address from a vector table through a separate instruction-side memory port. The two jobs run on their own and do not wait for each other. The block announces that the handler may start only after the slower of the two has finished.

On an exception return, the block reads the eight stacked words back through the data-side port. It then presents the restored context, the restored program counter and the adjusted stack pointer.

The surrounding core supplies the following, all sampled in the cycle the request is accepted:
- the exception number,
- the vector-table base,
- the current stack pointer,
- the eight context words, packed into one vector.

Top module: `exc_stack_seq`

## Requirements
- R1: An accepted entry writes exactly eight words to ascending word addresses, starting at the entry stack pointer minus 32. Word k of `ctx_in` (bits 32k+31..32k) goes to address SP-32+4k. The order of k is R0, R1, R2, R3, R12, LR, PC, PSR for k = 0..7.
- R2: At entry completion, `sp_out` equals the entry stack pointer minus 32.
- R3: An accepted entry issues exactly one instruction-port read, at address `vt_base + 4*exc_num`.
- R4: In the first cycle after acceptance, the first stack write and the vector read are both presented (`d_valid` with `d_write`, and `i_valid`).
- R5: A request held by `d_ready` or `i_ready` low stalls only its own port; the other port's sequence keeps completing.
- R6: `entry_done` is a one-cycle strobe. It rises on the clock edge after the edge at which the later of two events occurs: the last stack write is accepted, or the vector response is taken. `handler_addr` then equals the fetched word.
- R7: `busy` is high from the edge that accepts a request until the completion strobe. While `busy` is high, `exc_req` and `exc_ret` are ignored: no extra bus traffic and no second completion.
- R8: An accepted return issues eight data-port reads at ascending addresses from `sp_in`. Each read completes with `d_rvalid` before the next is issued. Word k read fills `ret_ctx` word k.
- R9: On return, `ret_done` rises one edge after the last read response is taken. At that point `ret_pc` equals restored word 6 and `sp_out` equals `sp_in + 32`. No writes occur during a return.
- R10: After reset, `busy`, `d_valid`, `i_valid`, `entry_done` and `ret_done` are all low.
- R11: If `exc_req` and `exc_ret` are both high in an idle cycle, the entry is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception entry request |
| exc_num | input | VW | Exception number for the vector lookup |
| exc_ret | input | 1 | Exception return request |
| vt_base | input | AW | Vector table base address |
| sp_in | input | AW | Current stack pointer |
| ctx_in | input | 8*DW | Context words, word k in bits 32k+31..32k |
| busy | output | 1 | Sequence in progress |
| entry_done | output | 1 | Handler may start (strobe) |
| handler_addr | output | DW | Fetched handler start address |
| sp_out | output | AW | Stack pointer after entry or return |
| ret_done | output | 1 | Return restore complete (strobe) |
| ret_pc | output | DW | Restored program counter |
| ret_ctx | output | 8*DW | Restored context words |
| d_valid | output | 1 | Data port request valid |
| d_write | output | 1 | Data port request is a write |
| d_addr | output | AW | Data port address |
| d_wdata | output | DW | Data port write data |
| d_ready | input | 1 | Data port accepts request |
| d_rvalid | input | 1 | Data port read response valid |
| d_rdata | input | DW | Data port read data |
| i_valid | output | 1 | Instruction port read valid |
| i_addr | output | AW | Instruction port address |
| i_ready | input | 1 | Instruction port accepts request |
| i_rvalid | input | 1 | Instruction port response valid |
| i_rdata | input | DW | Instruction port read data |

## Verification
The hardest case to reach is the one where each port is the late finisher: one port stalls for most of the entry while the other runs freely, and completion must follow whichever of the two ends last.

The bench drives each port's ready line from its own 8-cycle stall mask and adds its own response latency. It sweeps every pairing of a set of masks and latencies, and adds runs where one port is blocked outright for a fixed window. The expected completion edge is computed as one more than the later of the recorded last-write edge and vector-response edge.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CTX_WORDS = 8;
  localparam int PC_SLOT   = 6;

  typedef enum logic [1:0] {
    DE_IDLE,
    DE_PUSH,
    DE_POP_REQ,
    DE_POP_WAIT
  } de_state_t;

  typedef enum logic [1:0] {
    VF_IDLE,
    VF_REQ,
    VF_WAIT
  } vf_state_t;

  typedef enum logic [1:0] {
    TC_IDLE,
    TC_ENTRY,
    TC_EXIT
  } tc_state_t;
endpackage

// File: rtl/exc_stack_port.sv
module exc_stack_port
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NW = CTX_WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_start,
  input  logic             pop_start,
  input  logic [AW-1:0]    base_addr,
  input  logic [NW*DW-1:0] ctx_in,
  output logic             d_valid,
  output logic             d_write,
  output logic [AW-1:0]    d_addr,
  output logic [DW-1:0]    d_wdata,
  input  logic             d_ready,
  input  logic             d_rvalid,
  input  logic [DW-1:0]    d_rdata,
  output logic             seq_done,
  output logic [NW*DW-1:0] ctx_out
);
  localparam int IW = (NW > 1) ? $clog2(NW) : 1;
  localparam logic [IW-1:0] LAST = IW'(NW - 1);

  de_state_t        state_q, state_d;
  logic [IW-1:0]    idx_q, idx_d;
  logic [AW-1:0]    base_q, base_d;
  logic [NW*DW-1:0] ctx_q, ctx_d;
  logic             done_q, done_d;

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    base_d  = base_q;
    ctx_d   = ctx_q;
    done_d  = 1'b0;
    case (state_q)
      DE_IDLE: begin
        if (push_start) begin
          state_d = DE_PUSH;
          idx_d   = '0;
          base_d  = base_addr;
          ctx_d   = ctx_in;
        end else if (pop_start) begin
          state_d = DE_POP_REQ;
          idx_d   = '0;
          base_d  = base_addr;
        end
      end
      DE_PUSH: begin
        if (d_ready) begin
          if (idx_q == LAST) begin
            done_d  = 1'b1;
            state_d = DE_IDLE;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      DE_POP_REQ: begin
        if (d_ready) state_d = DE_POP_WAIT;
      end
      DE_POP_WAIT: begin
        if (d_rvalid) begin
          ctx_d[idx_q*DW +: DW] = d_rdata;
          if (idx_q == LAST) begin
            done_d  = 1'b1;
            state_d = DE_IDLE;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = DE_POP_REQ;
          end
        end
      end
      default: state_d = DE_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= DE_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      ctx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
      ctx_q   <= ctx_d;
      done_q  <= done_d;
    end
  end

  assign d_valid  = (state_q == DE_PUSH) || (state_q == DE_POP_REQ);
  assign d_write  = (state_q == DE_PUSH);
  assign d_addr   = base_q + (AW'(idx_q) << 2);
  assign d_wdata  = ctx_q[idx_q*DW +: DW];
  assign seq_done = done_q;
  assign ctx_out  = ctx_q;

  // a stalled data request keeps address and data steady
  p_dhold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (d_valid && !d_ready) |=> (d_valid && $stable(d_addr) && $stable(d_wdata)));

  // consecutive pushes step up one word
  p_push_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == DE_PUSH && d_ready && idx_q != LAST) |=>
      (d_valid && d_write && d_addr == $past(d_addr) + AW'(4)));
endmodule

// File: rtl/exc_vec_port.sv
module exc_vec_port
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int VW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] tbl_base,
  input  logic [VW-1:0] vec_num,
  output logic          i_valid,
  output logic [AW-1:0] i_addr,
  input  logic          i_ready,
  input  logic          i_rvalid,
  input  logic [DW-1:0] i_rdata,
  output logic          fetch_done,
  output logic [DW-1:0] handler
);
  vf_state_t     state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] hnd_q, hnd_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    hnd_d   = hnd_q;
    done_d  = 1'b0;
    case (state_q)
      VF_IDLE: begin
        if (start) begin
          state_d = VF_REQ;
          addr_d  = tbl_base + (AW'(vec_num) << 2);
        end
      end
      VF_REQ: begin
        if (i_ready) state_d = VF_WAIT;
      end
      VF_WAIT: begin
        if (i_rvalid) begin
          hnd_d   = i_rdata;
          done_d  = 1'b1;
          state_d = VF_IDLE;
        end
      end
      default: state_d = VF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= VF_IDLE;
      addr_q  <= '0;
      hnd_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      hnd_q   <= hnd_d;
      done_q  <= done_d;
    end
  end

  assign i_valid    = (state_q == VF_REQ);
  assign i_addr     = addr_q;
  assign fetch_done = done_q;
  assign handler    = hnd_q;

  p_ihold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && !i_ready) |=> (i_valid && $stable(i_addr)));

  // exactly one read per fetch: after acceptance no further request until a response
  p_one_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (i_valid && i_ready) |=> !i_valid);
endmodule

// File: rtl/exc_stack_seq.sv
module exc_stack_seq
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int VW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    exc_req,
  input  logic [VW-1:0]           exc_num,
  input  logic                    exc_ret,
  input  logic [AW-1:0]           vt_base,
  input  logic [AW-1:0]           sp_in,
  input  logic [CTX_WORDS*DW-1:0] ctx_in,
  output logic                    busy,
  output logic                    entry_done,
  output logic [DW-1:0]           handler_addr,
  output logic [AW-1:0]           sp_out,
  output logic                    ret_done,
  output logic [DW-1:0]           ret_pc,
  output logic [CTX_WORDS*DW-1:0] ret_ctx,
  output logic                    d_valid,
  output logic                    d_write,
  output logic [AW-1:0]           d_addr,
  output logic [DW-1:0]           d_wdata,
  input  logic                    d_ready,
  input  logic                    d_rvalid,
  input  logic [DW-1:0]           d_rdata,
  output logic                    i_valid,
  output logic [AW-1:0]           i_addr,
  input  logic                    i_ready,
  input  logic                    i_rvalid,
  input  logic [DW-1:0]           i_rdata
);
  localparam int FRAME_BYTES = CTX_WORDS * (DW / 8);

  tc_state_t     state_q, state_d;
  logic          stk_seen_q, stk_seen_d;
  logic          vec_seen_q, vec_seen_d;
  logic          edone_q, edone_d;
  logic          rdone_q, rdone_d;
  logic [AW-1:0] sp_q, sp_d;

  logic          take_entry, take_exit;
  logic [AW-1:0] stk_base;
  logic          stk_done, vec_done;
  logic          stk_ok, vec_ok;

  assign take_entry = (state_q == TC_IDLE) && exc_req;
  assign take_exit  = (state_q == TC_IDLE) && !exc_req && exc_ret;
  assign stk_base   = take_entry ? (sp_in - AW'(FRAME_BYTES)) : sp_in;
  assign stk_ok     = stk_seen_q || stk_done;
  assign vec_ok     = vec_seen_q || vec_done;

  exc_stack_port #(.AW(AW), .DW(DW), .NW(CTX_WORDS)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_start (take_entry),
    .pop_start  (take_exit),
    .base_addr  (stk_base),
    .ctx_in     (ctx_in),
    .d_valid    (d_valid),
    .d_write    (d_write),
    .d_addr     (d_addr),
    .d_wdata    (d_wdata),
    .d_ready    (d_ready),
    .d_rvalid   (d_rvalid),
    .d_rdata    (d_rdata),
    .seq_done   (stk_done),
    .ctx_out    (ret_ctx)
  );

  exc_vec_port #(.AW(AW), .DW(DW), .VW(VW)) u_vec (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (take_entry),
    .tbl_base   (vt_base),
    .vec_num    (exc_num),
    .i_valid    (i_valid),
    .i_addr     (i_addr),
    .i_ready    (i_ready),
    .i_rvalid   (i_rvalid),
    .i_rdata    (i_rdata),
    .fetch_done (vec_done),
    .handler    (handler_addr)
  );

  always_comb begin
    state_d    = state_q;
    stk_seen_d = stk_seen_q;
    vec_seen_d = vec_seen_q;
    edone_d    = 1'b0;
    rdone_d    = 1'b0;
    sp_d       = sp_q;
    case (state_q)
      TC_IDLE: begin
        stk_seen_d = 1'b0;
        vec_seen_d = 1'b0;
        if (take_entry) begin
          state_d = TC_ENTRY;
          sp_d    = sp_in - AW'(FRAME_BYTES);
        end else if (take_exit) begin
          state_d = TC_EXIT;
          sp_d    = sp_in + AW'(FRAME_BYTES);
        end
      end
      TC_ENTRY: begin
        if (stk_ok && vec_ok) begin
          edone_d    = 1'b1;
          state_d    = TC_IDLE;
          stk_seen_d = 1'b0;
          vec_seen_d = 1'b0;
        end else begin
          stk_seen_d = stk_ok;
          vec_seen_d = vec_ok;
        end
      end
      TC_EXIT: begin
        if (stk_done) begin
          rdone_d = 1'b1;
          state_d = TC_IDLE;
        end
      end
      default: state_d = TC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= TC_IDLE;
      stk_seen_q <= 1'b0;
      vec_seen_q <= 1'b0;
      edone_q    <= 1'b0;
      rdone_q    <= 1'b0;
      sp_q       <= '0;
    end else begin
      state_q    <= state_d;
      stk_seen_q <= stk_seen_d;
      vec_seen_q <= vec_seen_d;
      edone_q    <= edone_d;
      rdone_q    <= rdone_d;
      sp_q       <= sp_d;
    end
  end

  assign busy       = (state_q != TC_IDLE);
  assign entry_done = edone_q;
  assign ret_done   = rdone_q;
  assign sp_out     = sp_q;
  assign ret_pc     = ret_ctx[PC_SLOT*DW +: DW];

  // vector read never starts without the first push beside it
  p_fetch_with_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(i_valid) |-> (d_valid && d_write));

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (exc_req || exc_ret)) |=> busy);

  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_done || ret_done) |-> !busy);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    entry_done |=> !entry_done);

  // no stores while restoring
  p_exit_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !i_valid && d_valid && $past(ret_done || !busy) && !d_write) |=> !(d_valid && d_write));
endmodule

// File: tb/tb_exc_stack_seq.sv
module tb_exc_stack_seq;
  localparam int CLK_NS = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int VW = 8;

  logic            clk, rst_n;
  logic            exc_req, exc_ret;
  logic [VW-1:0]   exc_num;
  logic [AW-1:0]   vt_base, sp_in;
  logic [8*DW-1:0] ctx_in;
  logic            busy, entry_done, ret_done;
  logic [DW-1:0]   handler_addr, ret_pc;
  logic [AW-1:0]   sp_out;
  logic [8*DW-1:0] ret_ctx;
  logic            d_valid, d_write, d_ready, d_rvalid;
  logic [AW-1:0]   d_addr;
  logic [DW-1:0]   d_wdata, d_rdata;
  logic            i_valid, i_ready, i_rvalid;
  logic [AW-1:0]   i_addr;
  logic [DW-1:0]   i_rdata;

  exc_stack_seq #(.AW(AW), .DW(DW), .VW(VW)) dut (.*);

  int tests = 0, fails = 0;
  int cyc = 0;
  logic [31:0] dmem [64];
  logic [7:0] d_pat, i_pat;
  int d_lat, i_lat, d_block, i_block;
  int wr_count, rd_count, i_reqs, ed_cnt, rt_cnt, ed_cyc, rt_cyc;
  int first_wr_edge, last_wr_edge, i_acc_edge, i_rsp_edge, last_rsp_edge;
  int rd_bad;
  logic [AW-1:0] i_last_addr, rd_base;
  logic d_pend, i_pend;
  int d_cnt, i_cnt;
  logic [5:0] d_pidx;
  logic [AW-1:0] i_paddr;

  initial begin
    clk = 0;
    forever #(CLK_NS/2) clk = ~clk;
  end

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] vec_word(logic [31:0] a);
    return a ^ 32'h5A00_0001;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    wr_count = 0; rd_count = 0; i_reqs = 0; ed_cnt = 0; rt_cnt = 0;
    first_wr_edge = -1; last_wr_edge = -1; i_acc_edge = -1; i_rsp_edge = -1;
    last_rsp_edge = -1; rd_bad = 0;
  endtask

  // bus responders, driven away from the active edge
  initial begin
    d_ready = 0; d_rvalid = 0; d_rdata = '0; i_ready = 0; i_rvalid = 0; i_rdata = '0;
    d_pend = 0; i_pend = 0; d_cnt = 0; i_cnt = 0; d_pidx = '0; i_paddr = '0;
    forever begin
      @(negedge clk);
      d_rvalid = 0;
      if (d_pend) begin
        if (d_cnt == 0) begin
          d_rvalid = 1; d_rdata = dmem[d_pidx]; d_pend = 0; last_rsp_edge = cyc + 1;
        end else d_cnt--;
      end
      i_rvalid = 0;
      if (i_pend) begin
        if (i_cnt == 0) begin
          i_rvalid = 1; i_rdata = vec_word(i_paddr); i_pend = 0; i_rsp_edge = cyc + 1;
        end else i_cnt--;
      end
      d_ready = !d_pat[(cyc + 1) % 8] && (cyc >= d_block);
      i_ready = !i_pat[(cyc + 1) % 8] && (cyc >= i_block);
      if (d_valid && d_ready) begin
        if (d_write) begin
          dmem[d_addr[7:2]] = d_wdata;
          wr_count++;
          if (first_wr_edge < 0) first_wr_edge = cyc + 1;
          last_wr_edge = cyc + 1;
        end else begin
          if (d_addr != rd_base + AW'(4 * rd_count)) rd_bad++;
          rd_count++;
          d_pend = 1; d_cnt = d_lat; d_pidx = d_addr[7:2];
        end
      end
      if (i_valid && i_ready) begin
        i_reqs++; i_last_addr = i_addr; i_acc_edge = cyc + 1;
        i_pend = 1; i_cnt = i_lat; i_paddr = i_addr;
      end
      if (entry_done) begin ed_cnt++; ed_cyc = cyc; end
      if (ret_done) begin rt_cnt++; rt_cyc = cyc; end
    end
  end

  task automatic run_entry(int num, logic [31:0] sp, logic [7:0] dp, logic [7:0] ip,
                           int dl, int il, bit poke, bit both);
    logic [31:0] words [8];
    int exp_edge, w;
    d_pat = dp; i_pat = ip; d_lat = dl; i_lat = il;
    for (int k = 0; k < 64; k++) dmem[k] = 32'hDEAD_0000 + k;
    for (int k = 0; k < 8; k++) words[k] = 32'hC0DE_0000 + num * 256 + k * 17 + sp[11:0];
    @(negedge clk); #1;
    clear_log();
    exc_req = 1; exc_ret = both; exc_num = VW'(num); sp_in = sp;
    vt_base = 32'h0800_0000 + 32'(num % 3) * 32'h400;
    for (int k = 0; k < 8; k++) ctx_in[k*32 +: 32] = words[k];
    @(negedge clk); #1;
    exc_req = 0; exc_ret = 0;
    if (d_block == 0 && i_block == 0)
      check(d_valid && d_write && i_valid, "R4 both ports start together",
            {29'b0, d_valid, d_write, i_valid}, 32'h7);
    check(busy, "R7 busy after accept", 32'(busy), 1);
    if (poke) begin
      exc_req = 1; exc_ret = 1; exc_num = VW'(num + 1); sp_in = sp + 32'h40;
      @(negedge clk); #1;
      exc_req = 0; exc_ret = 0;
    end
    w = 0;
    while (ed_cnt == 0 && w < 300) begin @(negedge clk); #1; w++; end
    exp_edge = (last_wr_edge > i_rsp_edge ? last_wr_edge : i_rsp_edge) + 1;
    check(ed_cnt == 1, "R6 entry completes", 32'(ed_cnt), 1);
    check(ed_cyc == exp_edge, "R6 completion edge", 32'(ed_cyc), 32'(exp_edge));
    check(handler_addr == vec_word(vt_base + 32'(num) * 4), "R6 handler address",
          handler_addr, vec_word(vt_base + 32'(num) * 4));
    check(i_reqs == 1 && i_last_addr == vt_base + 32'(num) * 4, "R3 vector read address",
          i_last_addr, vt_base + 32'(num) * 4);
    check(sp_out == sp - 32, "R2 stack pointer after entry", sp_out, sp - 32);
    check(wr_count == 8, "R1 eight pushes", 32'(wr_count), 8);
    check(rd_count == 0, "R11 return dropped on entry", 32'(rd_count), 0);
    for (int k = 0; k < 8; k++) begin
      logic [31:0] a;
      a = sp - 32 + 32'(4 * k);
      check(dmem[a[7:2]] == words[k], "R1 stacked word", dmem[a[7:2]], words[k]);
    end
    repeat (4) @(negedge clk);
    #1;
    check(ed_cnt == 1 && !busy && i_reqs == 1 && wr_count == 8, "R7 request while busy ignored",
          32'(ed_cnt), 1);
  endtask

  task automatic run_exit(logic [31:0] sp, logic [7:0] dp, int dl);
    logic [31:0] words [8];
    int w;
    d_pat = dp; d_lat = dl; i_pat = 8'h00;
    for (int k = 0; k < 8; k++) begin
      logic [31:0] a;
      a = sp + 32'(4 * k);
      words[k] = 32'hB00B_0000 + sp[11:0] * 16 + k;
      dmem[a[7:2]] = words[k];
    end
    @(negedge clk); #1;
    clear_log();
    rd_base = sp;
    exc_ret = 1; sp_in = sp;
    @(negedge clk); #1;
    exc_ret = 0;
    w = 0;
    while (rt_cnt == 0 && w < 300) begin @(negedge clk); #1; w++; end
    check(rt_cnt == 1, "R9 return completes", 32'(rt_cnt), 1);
    check(rt_cyc == last_rsp_edge + 1, "R9 return edge", 32'(rt_cyc), 32'(last_rsp_edge + 1));
    check(rd_count == 8 && rd_bad == 0, "R8 ascending pops", 32'(rd_count), 8);
    check(wr_count == 0 && i_reqs == 0, "R9 no writes on return", 32'(wr_count), 0);
    for (int k = 0; k < 8; k++)
      check(ret_ctx[k*32 +: 32] == words[k], "R8 restored word", ret_ctx[k*32 +: 32], words[k]);
    check(ret_pc == words[6], "R9 restored pc", ret_pc, words[6]);
    check(sp_out == sp + 32, "R9 stack pointer after return", sp_out, sp + 32);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    int n;
    pats[0] = 8'h00; pats[1] = 8'h55; pats[2] = 8'h0F; pats[3] = 8'hB6;
    rst_n = 0; exc_req = 0; exc_ret = 0; exc_num = '0; vt_base = '0; sp_in = '0; ctx_in = '0;
    d_pat = 8'h00; i_pat = 8'h00; d_lat = 0; i_lat = 0; d_block = 0; i_block = 0;
    rd_base = '0; i_last_addr = '0; ed_cyc = 0; rt_cyc = 0;
    clear_log();
    repeat (3) @(negedge clk);
    check(!busy && !d_valid && !i_valid && !entry_done && !ret_done, "R10 reset state",
          {27'b0, busy, d_valid, i_valid, entry_done, ret_done}, 0);
    rst_n = 1;
    @(negedge clk);
    n = 0;
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int l = 0; l < 2; l++) begin
          run_entry((n * 37 + 3) % 256, 32'h2000_0040 + 32'((n % 4) * 32),
                    pats[a], pats[b], l, 2 - l, (n % 3) == 0, (n % 5) == 1);
          n++;
        end
    run_entry(255, 32'h2000_0100, 8'h00, 8'h00, 0, 0, 0, 0);
    run_entry(0, 32'h2000_0020, 8'h00, 8'h00, 0, 0, 0, 0);
    // R5: instruction port blocked while data port runs
    i_block = cyc + 25;
    run_entry(9, 32'h2000_0080, 8'h00, 8'h00, 0, 0, 0, 0);
    check(last_wr_edge < i_acc_edge, "R5 pushes finish while vector stalled",
          32'(last_wr_edge), 32'(i_acc_edge));
    i_block = 0;
    // R5: data port blocked while vector fetch runs
    d_block = cyc + 25;
    run_entry(17, 32'h2000_00C0, 8'h00, 8'h00, 0, 0, 0, 0);
    check(i_rsp_edge < first_wr_edge, "R5 vector finishes while pushes stalled",
          32'(i_rsp_edge), 32'(first_wr_edge));
    d_block = 0;
    for (int a = 0; a < 4; a++)
      for (int l = 0; l < 2; l++)
        run_exit(32'h2000_0020 + 32'(a * 48), pats[a], l * 2);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule